// File: doc/BRIEF.md
# Dual-lane Welford statistics reducer

The block reduces one stream of signed fixed-point samples to two independent running-statistics triples. Sample k goes to lane A when k is even and to lane B when k is odd. Each lane holds a count, a running mean and a sum of squared deviations, and updates them with the Welford recurrence. The lane counts are not counted up as samples arrive. They are seeded from the requested length N when the run starts, so lane A holds ceil(N/2) and lane B holds floor(N/2) before the first sample is taken.

A run begins with a one-cycle start pulse carrying N and a transpose mode bit. The block then takes N samples over a valid/ready stream. A single restoring divider forms delta/i for the mean update, so the stream stalls while the divider runs. When the last update is done the block raises a one-cycle done strobe. The six result words hold their values until the next accepted start. The transpose bit does not change the arithmetic; it only chooses the operation code the block reports back.

Top module: `wf_stats_reducer`

## Requirements
- R1: Sample index k counts accepted samples from 0 within a run. Even k updates only lane A (words 0..2) and odd k updates only lane B (words 3..5).
- R2: In the cycle after an accepted start, word 0 (n_A) equals ceil(N/2) and word 3 (n_B) equals floor(N/2). Both stay constant for the rest of the run.
- R3: With N = 0 the block raises done_o in the cycle after start, never raises in_ready_o, and all six words read zero.
- R4: result_o is six 32-bit words, with word w at bits [32w+31:32w], in this order: n_A, mean_A, M2_A, n_B, mean_B, M2_B. Counts are unsigned integers. Means and M2 are two's-complement with 8 fraction bits.
- R5: For sample x (16-bit signed Q8.8) going to a lane whose running index becomes i (1 for that lane's first sample), delta = x - mean. The new mean is mean + (delta / i), with the quotient truncated toward zero. M2 gains floor(delta * (x - new mean) / 256). M2 is never divided by the count.
- R6: opcode_o reads 0x61 after a start with transpose_i low and 0x82 after a start with transpose_i high. The arithmetic is identical in both cases. The reset value is 0x61.
- R7: in_ready_o is high only while the block waits for a sample. After each accepted sample it stays low for exactly 17 cycles: 16 division steps plus one update cycle.
- R8: done_o is high for exactly one cycle, in the cycle after the update of the N-th sample. busy_o is high from the cycle after start through the done cycle. The result words do not change between that done cycle and the next accepted start.
- R9: A start pulse while busy_o is high has no effect on the run, the counts, the opcode or the results.
- R10: After reset, result_o is zero, opcode_o is 0x61, and in_ready_o, done_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| count_i | input | CNT_W | Number of samples N for the run |
| transpose_i | input | 1 | Mode bit that selects the reported opcode |
| in_valid_i | input | 1 | Sample valid |
| in_data_i | input | DATA_W | Sample, signed Q8.8 |
| in_ready_o | output | 1 | Block can take a sample |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| opcode_o | output | 8 | Operation code of the last accepted start |
| result_o | output | 6*ACC_W | Six result words, word 0 in the low bits |

## Verification
The bound checker watches properties that can be judged locally on every cycle:
- done_o lasts a single cycle.
- in_ready_o drops after each handshake.
- The seeded counts and the opcode appear in the cycle after an accepted start.
- An empty run finishes at once.
- The results stay still while idle.
- A start pulse during a run leaves the opcode and counts alone.

The Welford arithmetic cannot be checked this way: the lane split, the signed truncating division and the floored M2 increment over whole sequences. The same goes for the exact 17-cycle stall. Only the bench's behavioural model shows these, running over ramps, alternating full-scale extremes, gapped streams and pseudo-random data.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DIV  = 2'd2,
    ST_DONE = 2'd3
  } wf_state_e;

  localparam int unsigned LANES       = 2;
  localparam int unsigned WORDS_LANE  = 3;
endpackage

// File: rtl/wf_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
module wf_divider #(
  parameter int unsigned DVD_W = 16,
  parameter int unsigned DVS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic [DVD_W-1:0] quotient_o
);
  localparam int unsigned STEP_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0]  rem_q;
  logic [DVD_W-1:0]  quo_q;
  logic [STEP_W-1:0] step_q;
  logic [DVS_W:0]    rem_sh;
  logic [DVS_W:0]    diff;
  logic              fits;
  logic              unused_div;

  always_comb begin
    rem_sh = {rem_q, quo_q[DVD_W-1]};
    diff   = rem_sh - {1'b0, divisor_i};
    fits   = rem_sh >= {1'b0, divisor_i};
  end
  assign unused_div = diff[DVS_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      step_q <= '0;
    end else if (load_i) begin
      rem_q  <= '0;
      quo_q  <= dividend_i;
      step_q <= STEP_W'(DVD_W);
    end else if (step_q != '0) begin
      rem_q  <= fits ? diff[DVS_W-1:0] : rem_sh[DVS_W-1:0];
      quo_q  <= {quo_q[DVD_W-2:0], fits};
      step_q <= step_q - 1'b1;
    end
  end

  assign busy_o     = step_q != '0;
  assign quotient_o = quo_q;
endmodule

// File: rtl/wf_lane.sv
// One Welford lane: seeded count, running mean, running M2.
module wf_lane #(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned FRAC_W  = 8,
  parameter int unsigned DELTA_W = 17
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     seed_i,
  input  logic [CNT_W-1:0]         seed_cnt_i,
  input  logic                     upd_i,
  input  logic signed [ACC_W-1:0]  x_i,
  input  logic signed [DELTA_W-1:0] delta_i,
  input  logic signed [DELTA_W-1:0] step_i,
  output logic [ACC_W-1:0]         cnt_o,
  output logic [ACC_W-1:0]         mean_o,
  output logic [ACC_W-1:0]         m2_o,
  output logic [CNT_W-1:0]         idx_o
);
  localparam int unsigned PROD_W = ACC_W + DELTA_W;

  logic [ACC_W-1:0]         cnt_q;
  logic signed [ACC_W-1:0]  mean_q;
  logic [ACC_W-1:0]         m2_q;
  logic [CNT_W-1:0]         idx_q;
  logic signed [ACC_W-1:0]  mean_new;
  logic signed [ACC_W-1:0]  resid;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] inc_full;
  logic                     unused_inc;

  always_comb begin
    mean_new = mean_q + {{(ACC_W-DELTA_W){step_i[DELTA_W-1]}}, step_i};
    resid    = x_i - mean_new;
    prod     = delta_i * resid;
    inc_full = prod >>> FRAC_W;
  end
  assign unused_inc = ^inc_full[PROD_W-1:ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mean_q <= '0;
      m2_q   <= '0;
      idx_q  <= '0;
    end else if (seed_i) begin
      cnt_q  <= {{(ACC_W-CNT_W){1'b0}}, seed_cnt_i};
      mean_q <= '0;
      m2_q   <= '0;
      idx_q  <= '0;
    end else if (upd_i) begin
      mean_q <= mean_new;
      m2_q   <= m2_q + inc_full[ACC_W-1:0];
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign mean_o = mean_q;
  assign m2_o   = m2_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/wf_ctrl.sv
// Run sequencing: idle -> receive <-> divide -> done.
module wf_ctrl
  import wf_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             in_valid_i,
  input  logic             div_busy_i,
  output logic             in_ready_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             seed_o,
  output logic             accept_o,
  output logic             upd_o,
  output logic             lane_o
);
  wf_state_e        state_q;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] taken_q;

  assign seed_o     = (state_q == ST_IDLE) && start_i;
  assign accept_o   = (state_q == ST_RECV) && in_valid_i;
  assign upd_o      = (state_q == ST_DIV) && !div_busy_i;
  assign in_ready_o = state_q == ST_RECV;
  assign busy_o     = state_q != ST_IDLE;
  assign done_o     = state_q == ST_DONE;
  assign lane_o     = taken_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      total_q <= '0;
      taken_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          total_q <= count_i;
          taken_q <= '0;
          state_q <= (count_i == '0) ? ST_DONE : ST_RECV;
        end
        ST_RECV: if (in_valid_i) begin
          taken_q <= taken_q + 1'b1;
          state_q <= ST_DIV;
        end
        ST_DIV: if (!div_busy_i) begin
          state_q <= (taken_q == total_q) ? ST_DONE : ST_RECV;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wf_stats_reducer.sv
module wf_stats_reducer
  import wf_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned CNT_W    = 16,
  parameter logic [7:0]  OP_PLAIN = 8'h61,
  parameter logic [7:0]  OP_TRANS = 8'h82
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [CNT_W-1:0]              count_i,
  input  logic                          transpose_i,
  input  logic                          in_valid_i,
  input  logic [DATA_W-1:0]             in_data_i,
  output logic                          in_ready_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [7:0]                    opcode_o,
  output logic [LANES*WORDS_LANE*ACC_W-1:0] result_o
);
  localparam int unsigned DELTA_W = DATA_W + 1;

  logic                     seed, accept, upd, lane_now, div_busy;
  logic [DATA_W-1:0]        quo;
  logic signed [ACC_W-1:0]  x_ext, x_q;
  logic signed [ACC_W-1:0]  delta_full;
  logic signed [DELTA_W-1:0] delta_now, delta_q, step;
  logic [DELTA_W-1:0]       mag;
  logic                     lane_q;
  logic [CNT_W-1:0]         divisor_q;
  logic [7:0]               opcode_q;
  logic [CNT_W:0]           cnt_p1;
  logic [CNT_W-1:0]         seed_cnt [LANES];
  logic [ACC_W-1:0]         cnt_w    [LANES];
  logic [ACC_W-1:0]         mean_w   [LANES];
  logic [ACC_W-1:0]         m2_w     [LANES];
  logic [CNT_W-1:0]         idx_w    [LANES];
  logic                     unused_top;

  wf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .count_i    (count_i),
    .in_valid_i (in_valid_i),
    .div_busy_i (div_busy),
    .in_ready_o (in_ready_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .seed_o     (seed),
    .accept_o   (accept),
    .upd_o      (upd),
    .lane_o     (lane_now)
  );

  // delta against the target lane's current mean
  always_comb begin
    x_ext      = {{(ACC_W-DATA_W){in_data_i[DATA_W-1]}}, in_data_i};
    delta_full = x_ext - $signed(mean_w[lane_now]);
    delta_now  = delta_full[DELTA_W-1:0];
    mag        = delta_now[DELTA_W-1] ? -delta_now : delta_now;
    step       = delta_q[DELTA_W-1] ? -$signed({1'b0, quo}) : $signed({1'b0, quo});
    cnt_p1     = {1'b0, count_i} + 1'b1;
  end
  assign unused_top = ^{delta_full[ACC_W-1:DELTA_W], mag[DELTA_W-1], cnt_p1[0]};

  // lane A rounds the odd element up, lane B down
  assign seed_cnt[0] = cnt_p1[CNT_W:1];
  assign seed_cnt[1] = {1'b0, count_i[CNT_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q       <= '0;
      delta_q   <= '0;
      lane_q    <= 1'b0;
      divisor_q <= '0;
      opcode_q  <= OP_PLAIN;
    end else begin
      if (seed) opcode_q <= transpose_i ? OP_TRANS : OP_PLAIN;
      if (accept) begin
        x_q       <= x_ext;
        delta_q   <= delta_now;
        lane_q    <= lane_now;
        divisor_q <= idx_w[lane_now] + 1'b1;
      end
    end
  end

  wf_divider #(.DVD_W(DATA_W), .DVS_W(CNT_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .dividend_i (mag[DATA_W-1:0]),
    .divisor_i  (divisor_q),
    .busy_o     (div_busy),
    .quotient_o (quo)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wf_lane #(
      .ACC_W(ACC_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W), .DELTA_W(DELTA_W)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .seed_i     (seed),
      .seed_cnt_i (seed_cnt[g]),
      .upd_i      (upd && (lane_q == 1'(g))),
      .x_i        (x_q),
      .delta_i    (delta_q),
      .step_i     (step),
      .cnt_o      (cnt_w[g]),
      .mean_o     (mean_w[g]),
      .m2_o       (m2_w[g]),
      .idx_o      (idx_w[g])
    );
    assign result_o[(WORDS_LANE*g+0)*ACC_W +: ACC_W] = cnt_w[g];
    assign result_o[(WORDS_LANE*g+1)*ACC_W +: ACC_W] = mean_w[g];
    assign result_o[(WORDS_LANE*g+2)*ACC_W +: ACC_W] = m2_w[g];
  end

  assign opcode_o = opcode_q;
endmodule

// File: rtl/wf_stats_reducer_chk.sv
module wf_stats_reducer_chk #(
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned CNT_W    = 16,
  parameter logic [7:0]  OP_PLAIN = 8'h61,
  parameter logic [7:0]  OP_TRANS = 8'h82
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [CNT_W-1:0]     count_i,
  input logic                 transpose_i,
  input logic                 in_valid_i,
  input logic                 in_ready_o,
  input logic                 busy_o,
  input logic                 done_o,
  input logic [7:0]           opcode_o,
  input logic [6*ACC_W-1:0]   result_o
);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  // R2
  seed_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=>
      result_o[ACC_W-1:0] == ACC_W'(({1'b0, $past(count_i)} + 1'b1) >> 1));

  // R2
  seed_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=>
      result_o[4*ACC_W-1:3*ACC_W] == ACC_W'($past(count_i) >> 1));

  // R3
  empty_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && count_i == '0) |=> (done_o && !in_ready_o));

  // R6
  opcode_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> opcode_o == ($past(transpose_i) ? OP_TRANS : OP_PLAIN));

  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> ($stable(opcode_o) && $stable(result_o[ACC_W-1:0])
                             && $stable(result_o[4*ACC_W-1:3*ACC_W])));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(result_o));
endmodule

bind wf_stats_reducer wf_stats_reducer_chk #(
  .ACC_W(ACC_W), .CNT_W(CNT_W), .OP_PLAIN(OP_PLAIN), .OP_TRANS(OP_TRANS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .count_i     (count_i),
  .transpose_i (transpose_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .opcode_o    (opcode_o),
  .result_o    (result_o)
);

// File: tb/wf_stats_reducer_tb.sv
module wf_stats_reducer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int ACC_W  = 32;
  localparam int CNT_W  = 16;
  localparam int WDOG   = 100000;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               start_i = 1'b0;
  logic [CNT_W-1:0]   count_i = '0;
  logic               transpose_i = 1'b0;
  logic               in_valid_i = 1'b0;
  logic [DATA_W-1:0]  in_data_i = '0;
  logic               in_ready_o, busy_o, done_o;
  logic [7:0]         opcode_o;
  logic [6*ACC_W-1:0] result_o;

  wf_stats_reducer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
    .transpose_i(transpose_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .busy_o(busy_o), .done_o(done_o),
    .opcode_o(opcode_o), .result_o(result_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // behavioural model: 0 idle, 1 waiting for sample, 2 working, 3 done
  int m_state = 0;
  int m_wait, m_n, m_k;
  int m_cnt[2], m_mean[2], m_m2[2], m_idx[2];
  int m_op = 'h61;

  function automatic int word(int w);
    return int'(result_o[w*ACC_W +: ACC_W]);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s act=%0d (0x%0h) exp=%0d (0x%0h) t=%0t", tag, act, act, exp, exp, $time);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_op = 'h61; m_n = 0; m_k = 0; m_wait = 0;
      for (int l = 0; l < 2; l++) begin m_cnt[l] = 0; m_mean[l] = 0; m_m2[l] = 0; m_idx[l] = 0; end
    end else begin
      case (m_state)
        0: if (start_i) begin
          m_n = int'(count_i); m_k = 0;
          m_cnt[0] = (m_n + 1) / 2; m_cnt[1] = m_n / 2;
          for (int l = 0; l < 2; l++) begin m_mean[l] = 0; m_m2[l] = 0; m_idx[l] = 0; end
          m_op = transpose_i ? 'h82 : 'h61;
          m_state = (m_n == 0) ? 3 : 1;
        end
        1: if (in_valid_i) begin
          int l, x, d, i, mn;
          l = m_k % 2;
          x = int'($signed(in_data_i));
          i = m_idx[l] + 1;
          d = x - m_mean[l];
          mn = m_mean[l] + d / i;
          m_m2[l] = m_m2[l] + int'((longint'(d) * longint'(x - mn)) >>> 8);
          m_mean[l] = mn;
          m_idx[l] = i;
          m_k++;
          m_wait = 17;
          m_state = 2;
        end
        2: begin
          m_wait--;
          if (m_wait == 0) m_state = (m_k == m_n) ? 3 : 1;
        end
        default: m_state = 0;
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(in_ready_o == (m_state == 1), "R7 in_ready", int'(in_ready_o), int'(m_state == 1));
      chk(done_o == (m_state == 3), "R8 done", int'(done_o), int'(m_state == 3));
      chk(busy_o == (m_state != 0), "R8 R9 busy", int'(busy_o), int'(m_state != 0));
      chk(int'(opcode_o) == m_op, "R6 opcode", int'(opcode_o), m_op);
      chk(word(0) == m_cnt[0], "R2 R4 n_A", word(0), m_cnt[0]);
      chk(word(3) == m_cnt[1], "R2 R4 n_B", word(3), m_cnt[1]);
      if (m_state == 0 || m_state == 3) begin
        string tg;
        tg = (m_n == 0) ? "R3 zero result" : "R1 R5 lane stats";
        chk(word(1) == m_mean[0], {tg, " mean_A"}, word(1), m_mean[0]);
        chk(word(2) == m_m2[0],   {tg, " M2_A"},   word(2), m_m2[0]);
        chk(word(4) == m_mean[1], {tg, " mean_B"}, word(4), m_mean[1]);
        chk(word(5) == m_m2[1],   {tg, " M2_B"},   word(5), m_m2[1]);
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WDOG) begin
      n_tests++; n_fail++;
      $display("[TB] FAIL watchdog R8 act=%0d exp<=%0d", cycles, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic int dval(int kind, int i);
    case (kind)
      1:       return i * 37 - 100;
      2:       return ((i % 4) < 2) ? 32767 : -32768;
      default: return ((i * 7919 + kind * 104729) % 65536) - 32768;
    endcase
  endfunction

  // gap: insert an idle cycle before every sample; inject_at: start pulse while busy (R9)
  task automatic run(int n, bit tr, int kind, bit gap, int inject_at);
    int sent; bit stall; bit injected;
    sent = 0; stall = 1'b0; injected = 1'b0;
    @(negedge clk_i);
    start_i = 1'b1; count_i = CNT_W'(n); transpose_i = tr;
    @(negedge clk_i);
    start_i = 1'b0;
    while (sent < n) begin
      if (in_valid_i) begin sent++; in_valid_i = 1'b0; end
      start_i = 1'b0;
      if (inject_at >= 0 && sent == inject_at && !injected) begin
        start_i = 1'b1; count_i = CNT_W'(n + 3); transpose_i = ~tr; injected = 1'b1;
      end
      if (sent < n && in_ready_o) begin
        if (gap && !stall) stall = 1'b1;
        else begin
          stall = 1'b0; in_valid_i = 1'b1; in_data_i = DATA_W'(dval(kind, sent));
        end
      end
      if (sent < n) @(negedge clk_i);
    end
    start_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(result_o == '0, "R10 result", int'(result_o[31:0]), 0);
    chk(opcode_o == 8'h61, "R10 opcode", int'(opcode_o), 'h61);
    chk(!in_ready_o && !done_o && !busy_o, "R10 flags",
        int'({in_ready_o, done_o, busy_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run(0, 1'b0, 1, 1'b0, -1);   // R3
    run(1, 1'b0, 1, 1'b0, -1);
    run(5, 1'b1, 1, 1'b0, -1);   // R6 transpose, same arithmetic
    run(8, 1'b0, 2, 1'b1, -1);   // R5 full-scale deltas, gapped stream
    run(6, 1'b0, 3, 1'b0, 2);    // R9 start while busy
    run(7, 1'b1, 2, 1'b0, -1);
    run(40, 1'b0, 5, 1'b1, 11);  // R1 R5 long pseudo-random
    run(0, 1'b1, 1, 1'b0, -1);   // R3 empty after data
    run(2, 1'b0, 4, 1'b0, -1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule